// File: doc/BRIEF.md
# Per-Bit Access Policy Control Register

This block is one 32-bit memory-mapped register in which every bit position follows its own software access rule. A plain bus port carries an address, a write strobe, a read strobe, write data and read data. A bit may be plain storage. It may change as a side effect of being read. It may respond to a written 1 or a written 0 by setting, clearing or toggling. It may combine a write effect with a read effect. It may also accept only the first write after reset.

Read data is returned in the same cycle as the read strobe. Every state change caused by a read or a write shows from the next clock edge onward. One hardware status input feeds the read-only bit. The full stored contents, including bits that software cannot read back, are presented to the surrounding logic on a control output.

Top module: `mixed_access_reg`

## Requirements
- R1: An active-low reset clears every stored bit and both write-once lock flags; with no read strobe, `rdata` is 0.
- R2: A read (rd_en high, addr equal to the register address 0) returns data combinationally in that cycle. Bit 31 shows `hw_status`. Bits 30..12 and bit 7 show their stored values. Bits 11..8, bit 6 and bits 5..0 read as 0. Without a matching read, `rdata` is 0.
- R3: Bits 30, 27 and 26 load the written data bit on a write, and an access whose address does not match changes nothing.
- R4: On a read, bits 29 and 27 clear, bits 28 and 26 set, bit 15 clears and bit 14 sets, unless a write effect on the same bit applies.
- R5: Any write clears bit 25 and sets bit 24, regardless of the data.
- R6: A write sets bit 23 and a read clears it; a write clears bit 22 and a read sets it.
- R7: Writing a 1 clears bit 21, sets bit 20 and toggles bit 19; writing a 0 leaves them unchanged.
- R8: Writing a 0 clears bit 18, sets bit 17 and toggles bit 16; writing a 1 leaves them unchanged.
- R9: Writing a 1 sets bit 15 and clears bit 14; writing a 0 sets bit 13 and clears bit 12. Bit 13 clears and bit 12 sets on a read.
- R10: Bits 11 and 9 store written data, bit 10 clears and bit 8 sets on any write; their values are visible only on `ctrl_q`.
- R11: Bits 7 and 6 take the data of the first write after reset only; later writes leave them unchanged until the next reset.
- R12: When a read and a write hit the same bit in one cycle, the write effect wins; the read effect applies only if the write has no effect on that bit.
- R13: `ctrl_q` presents bit 31 as `hw_status`, bits 30..6 as the stored state and bits 5..0 as 0, and reflects each access from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (8) | Access address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid in the cycle of rd_en |
| hw_status | input | 1 | Hardware value shown on the read-only bit |
| ctrl_q | output | DATA_W (32) | Stored register contents presented to logic |

## Verification
Read data has zero latency: it reflects the state held before the access. It is sampled one nanosecond after the strobes are driven on the falling edge. Write effects and read side effects land on the next rising edge, so `ctrl_q` is sampled one nanosecond after that edge, before the next access is driven. Mixed read-and-write cycles are checked with fields masked per requirement, so each tag is tied to the bits it governs.

// File: rtl/mapr_pkg.sv
package mapr_pkg;

  typedef enum logic [4:0] {
    P_RSV, P_RO, P_RW, P_RC, P_RS, P_WRC, P_WRS, P_WC, P_WS,
    P_WSRC, P_WCRS, P_W1C, P_W1S, P_W1T, P_W0C, P_W0S, P_W0T,
    P_W1SRC, P_W1CRS, P_W0SRC, P_W0CRS, P_WO, P_WOC, P_WORZ,
    P_WOS, P_ONCE, P_WO_ONCE
  } pol_e;

  // Bit position to policy map; positions outside the list are reserved.
  function automatic pol_e pol_of(input int idx);
    case (idx)
      31: return P_RO;
      30: return P_RW;
      29: return P_RC;
      28: return P_RS;
      27: return P_WRC;
      26: return P_WRS;
      25: return P_WC;
      24: return P_WS;
      23: return P_WSRC;
      22: return P_WCRS;
      21: return P_W1C;
      20: return P_W1S;
      19: return P_W1T;
      18: return P_W0C;
      17: return P_W0S;
      16: return P_W0T;
      15: return P_W1SRC;
      14: return P_W1CRS;
      13: return P_W0SRC;
      12: return P_W0CRS;
      11: return P_WO;
      10: return P_WOC;
      9:  return P_WORZ;
      8:  return P_WOS;
      7:  return P_ONCE;
      6:  return P_WO_ONCE;
      default: return P_RSV;
    endcase
  endfunction

  function automatic logic is_readable(input pol_e p);
    return !(p inside {P_RSV, P_WO, P_WOC, P_WORZ, P_WOS, P_WO_ONCE});
  endfunction

  function automatic logic has_store(input pol_e p);
    return !(p inside {P_RSV, P_RO});
  endfunction

  function automatic logic is_once(input pol_e p);
    return p inside {P_ONCE, P_WO_ONCE};
  endfunction

  // Next stored value: a write effect, if any, overrides a read effect.
  function automatic logic next_bit(input pol_e p, input logic cur,
                                    input logic locked, input logic wr,
                                    input logic wb, input logic rd);
    logic w_act, w_val, r_act, r_val;
    w_act = 1'b0; w_val = cur;
    r_act = 1'b0; r_val = cur;
    case (p)
      P_RW, P_WRC, P_WRS, P_WO, P_WORZ: begin w_act = wr; w_val = wb; end
      P_WC, P_WOC, P_WCRS:             begin w_act = wr; w_val = 1'b0; end
      P_WS, P_WOS, P_WSRC:             begin w_act = wr; w_val = 1'b1; end
      P_W1C, P_W1CRS: begin w_act = wr & wb;  w_val = 1'b0; end
      P_W1S, P_W1SRC: begin w_act = wr & wb;  w_val = 1'b1; end
      P_W1T:          begin w_act = wr & wb;  w_val = ~cur; end
      P_W0C, P_W0CRS: begin w_act = wr & ~wb; w_val = 1'b0; end
      P_W0S, P_W0SRC: begin w_act = wr & ~wb; w_val = 1'b1; end
      P_W0T:          begin w_act = wr & ~wb; w_val = ~cur; end
      P_ONCE, P_WO_ONCE: begin w_act = wr & ~locked; w_val = wb; end
      default: begin w_act = 1'b0; w_val = cur; end
    endcase
    case (p)
      P_RC, P_WRC, P_WSRC, P_W1SRC, P_W0SRC: begin r_act = rd; r_val = 1'b0; end
      P_RS, P_WRS, P_WCRS, P_W1CRS, P_W0CRS: begin r_act = rd; r_val = 1'b1; end
      default: begin r_act = 1'b0; r_val = cur; end
    endcase
    if (w_act)      return w_val;
    else if (r_act) return r_val;
    else            return cur;
  endfunction

endpackage

// File: rtl/mapr_decode.sv
module mapr_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic sel;
  assign sel    = (addr == REG_ADDR);
  assign wr_hit = wr_en & sel;
  assign rd_hit = rd_en & sel;
endmodule

// File: rtl/mapr_bit_cell.sv
module mapr_bit_cell
  import mapr_pkg::*;
#(
  parameter pol_e POL = P_RW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic rd_hit,
  input  logic wbit,
  output logic q
);
  logic lock_q;
  logic q_nxt;

  if (is_once(POL)) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock_q <= 1'b0;
      else if (wr_hit) lock_q <= 1'b1;
    end
    // Once locked, the bit holds until reset.
    p_once_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(q));
  end else begin : g_nolock
    assign lock_q = 1'b0;
  end

  assign q_nxt = next_bit(POL, q, lock_q, wr_hit, wbit, rd_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  if (POL == P_W1T) begin : g_a_w1t
    p_w1t_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wbit) |=> (q != $past(q)));
  end
  if (POL == P_W0T) begin : g_a_w0t
    p_w0t_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !wbit) |=> (q != $past(q)));
  end
  if (POL inside {P_WS, P_WOS}) begin : g_a_ws
    p_write_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> q);
  end
  if (POL == P_RC) begin : g_a_rc
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> !q);
  end
  if (POL == P_RS) begin : g_a_rs
    p_read_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> q);
  end
  if (POL == P_WSRC) begin : g_a_prio
    p_write_beats_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && rd_hit) |=> q);
  end
  if (POL == P_RW) begin : g_a_rw
    p_rw_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (q == $past(wbit)));
  end
endmodule

// File: rtl/mapr_read_mux.sv
module mapr_read_mux #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] READ_MASK = '1
) (
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] q_vec,
  output logic [DATA_W-1:0] rdata
);
  assign rdata = rd_hit ? (q_vec & READ_MASK) : '0;
endmodule

// File: rtl/mixed_access_reg.sv
module mixed_access_reg
  import mapr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              hw_status,
  output logic [DATA_W-1:0] ctrl_q
);

  function automatic logic [DATA_W-1:0] calc_read_mask();
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = is_readable(pol_of(i));
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] calc_store_mask();
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = has_store(pol_of(i));
    return m;
  endfunction

  localparam logic [DATA_W-1:0] READ_MASK  = calc_read_mask();
  localparam logic [DATA_W-1:0] STORE_MASK = calc_store_mask();

  logic              wr_hit, rd_hit;
  logic [DATA_W-1:0] q_vec;
  logic              unused_wdata_bits;

  assign unused_wdata_bits = ^(wdata & ~STORE_MASK);

  mapr_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_decode (
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .wr_hit(wr_hit),
    .rd_hit(rd_hit)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam pol_e P = pol_of(i);
    if (P == P_RO) begin : g_ro
      assign q_vec[i] = hw_status;
    end else if (P == P_RSV) begin : g_rsv
      assign q_vec[i] = 1'b0;
    end else begin : g_cell
      mapr_bit_cell #(.POL(P)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hit(wr_hit),
        .rd_hit(rd_hit),
        .wbit  (wdata[i]),
        .q     (q_vec[i])
      );
    end
  end

  mapr_read_mux #(.DATA_W(DATA_W), .READ_MASK(READ_MASK)) u_rmux (
    .rd_hit(rd_hit),
    .q_vec (q_vec),
    .rdata (rdata)
  );

  assign ctrl_q = q_vec;

  // Stored bits change only in the cycle after a matching access.
  p_quiet_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !rd_hit) |=> ((ctrl_q & STORE_MASK) == $past(ctrl_q & STORE_MASK)));

  // Reset leaves every stored bit at zero.
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> ((ctrl_q & STORE_MASK) == '0));

endmodule

// File: tb/mixed_access_reg_tb_top.sv
module mixed_access_reg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        hw_status = 1'b0;
  logic [31:0] rdata, ctrl_q;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  mixed_access_reg dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .hw_status(hw_status), .ctrl_q(ctrl_q)
  );

  // Reference state: m holds bits 30..6, lk is the shared write-once lock.
  logic [31:0] m;
  logic        lk;
  logic [31:0] rd_s, ctrl_s;

  // Entry layout: {addr[7:0], wr, rd, hw, wdata[31:0]}
  localparam int NV = 12;
  localparam logic [42:0] VEC [0:NV-1] = '{
    {8'h00, 1'b0, 1'b1, 1'b0, 32'h0000_0000},
    {8'h00, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF},
    {8'h00, 1'b0, 1'b1, 1'b1, 32'h0000_0000},
    {8'h00, 1'b1, 1'b1, 1'b1, 32'h0000_0000},
    {8'h00, 1'b1, 1'b0, 1'b0, 32'h5A5A_5A5A},
    {8'h00, 1'b1, 1'b1, 1'b0, 32'hA5A5_A5A5},
    {8'h10, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF},
    {8'h00, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
    {8'h00, 1'b1, 1'b0, 1'b0, 32'h0000_0000},
    {8'h00, 1'b0, 1'b1, 1'b1, 32'h0000_0000},
    {8'h00, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF},
    {8'h00, 1'b0, 1'b1, 1'b0, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp, input logic [31:0] mask);
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act & mask, exp & mask);
    end
  endtask

  task automatic op(input logic [7:0] a, input logic w, input logic r,
                    input logic h, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = w; rd_en = r; hw_status = h; wdata = d;
    #1 rd_s = rdata;
    @(posedge clk);
    #1 ctrl_s = ctrl_q;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m = '0; lk = 1'b0;
  endtask

  function automatic logic [31:0] exp_read(input logic [31:0] s, input logic h);
    return {h, s[30:12], 4'b0000, s[7], 7'b0};
  endfunction

  task automatic model_step(input logic wr, input logic rd, input logic [31:0] w);
    logic [31:0] n;
    n = m;
    if (wr) n[30] = w[30];
    if (rd) n[29] = 1'b0;
    if (rd) n[28] = 1'b1;
    n[27] = wr ? w[27] : (rd ? 1'b0 : m[27]);
    n[26] = wr ? w[26] : (rd ? 1'b1 : m[26]);
    if (wr) begin n[25] = 1'b0; n[24] = 1'b1; end
    n[23] = wr ? 1'b1 : (rd ? 1'b0 : m[23]);
    n[22] = wr ? 1'b0 : (rd ? 1'b1 : m[22]);
    if (wr && w[21])  n[21] = 1'b0;
    if (wr && w[20])  n[20] = 1'b1;
    if (wr && w[19])  n[19] = ~m[19];
    if (wr && !w[18]) n[18] = 1'b0;
    if (wr && !w[17]) n[17] = 1'b1;
    if (wr && !w[16]) n[16] = ~m[16];
    n[15] = (wr && w[15])  ? 1'b1 : (rd ? 1'b0 : m[15]);
    n[14] = (wr && w[14])  ? 1'b0 : (rd ? 1'b1 : m[14]);
    n[13] = (wr && !w[13]) ? 1'b1 : (rd ? 1'b0 : m[13]);
    n[12] = (wr && !w[12]) ? 1'b0 : (rd ? 1'b1 : m[12]);
    if (wr) begin n[11] = w[11]; n[10] = 1'b0; n[9] = w[9]; n[8] = 1'b1; end
    if (wr && !lk) begin n[7] = w[7]; n[6] = w[6]; end
    if (wr) lk = 1'b1;
    n[31] = 1'b0; n[5:0] = '0;
    m = n;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R1 ctrl after reset", ctrl_q, 32'h0, '1);
    chk("R1 rdata idle", rdata, 32'h0, '1);

    // Table walk against the reference model (R2 read data, R13 next-cycle state)
    for (int k = 0; k < NV; k++) begin
      logic [42:0] v;
      logic hit;
      logic [31:0] erd;
      v = VEC[k];
      op(v[42:35], v[34], v[33], v[32], v[31:0]);
      hit = (v[42:35] == 8'h00);
      erd = (hit && v[33]) ? exp_read(m, v[32]) : 32'h0;
      chk("R2 table read", rd_s, erd, '1);
      model_step(hit && v[34], hit && v[33], v[31:0]);
      chk("R13 table ctrl", ctrl_s, {v[32], m[30:6], 6'b0}, '1);
    end

    // Directed sequence with hand-computed values
    do_reset();
    op(8'h00, 1'b0, 1'b1, 1'b1, 32'h0);
    chk("R2 read after reset", rd_s, 32'h8000_0000, '1);
    chk("R4 read-set bits", ctrl_s, 32'h9440_5000, '1);

    op(8'h00, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF);
    chk("R2 no read strobe", rd_s, 32'h0, '1);
    chk("R3 load ones", ctrl_s, 32'hDD98_9BC0, 32'h4C00_0000);
    chk("R5 any write", ctrl_s, 32'hDD98_9BC0, 32'h0300_0000);
    chk("R6 write effects", ctrl_s, 32'hDD98_9BC0, 32'h00C0_0000);
    chk("R7 write one", ctrl_s, 32'hDD98_9BC0, 32'h0038_0000);
    chk("R8 ones ignored", ctrl_s, 32'hDD98_9BC0, 32'h0007_0000);
    chk("R9 write one fields", ctrl_s, 32'hDD98_9BC0, 32'h0000_F000);
    chk("R10 write-only", ctrl_s, 32'hDD98_9BC0, 32'h0000_0F00);
    chk("R11 first write", ctrl_s, 32'hDD98_9BC0, 32'h0000_00C0);

    op(8'h00, 1'b1, 1'b0, 1'b1, 32'h0000_0000);
    chk("R7 zeros ignored", ctrl_s, 32'h919B_A1C0, 32'h0038_0000);
    chk("R8 write zero", ctrl_s, 32'h919B_A1C0, 32'h0007_0000);
    chk("R9 write zero fields", ctrl_s, 32'h919B_A1C0, 32'h0000_F000);
    chk("R10 write-only zero", ctrl_s, 32'h919B_A1C0, 32'h0000_0F00);
    chk("R11 second write locked", ctrl_s, 32'h919B_A1C0, 32'h0000_00C0);

    op(8'h00, 1'b1, 1'b1, 1'b1, 32'h0000_0000);
    chk("R2 mixed read", rd_s, 32'h919B_A080, '1);
    chk("R12 write wins", ctrl_s, 32'h919A_61C0, 32'h04C0_3000);
    chk("R4 read effects", ctrl_s, 32'h919A_61C0, 32'h3000_C000);
    chk("R13 full state", ctrl_s, 32'h919A_61C0, '1);

    op(8'h10, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF);
    chk("R2 miss read", rd_s, 32'h0, '1);
    chk("R3 miss ignored", ctrl_s, 32'h919A_61C0, '1);

    op(8'h00, 1'b0, 1'b1, 1'b0, 32'h0);
    chk("R2 hw low read", rd_s, 32'h119A_6080, '1);

    do_reset();
    #1;
    chk("R1 second reset", ctrl_q, 32'h0, '1);
    op(8'h00, 1'b1, 1'b0, 1'b0, 32'h0000_00C0);
    chk("R11 lock cleared by reset", ctrl_s, 32'h0000_00C0, 32'h0000_00C0);
    op(8'h00, 1'b1, 1'b0, 1'b0, 32'h0000_0000);
    chk("R11 relocked", ctrl_s, 32'h0000_00C0, 32'h0000_00C0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule